// File: doc/BRIEF.md
# Byte-Order Conversion Unit

This unit carries out the two byte-order conversion instructions of a little-endian bytecode machine. Each request carries the 8-bit opcode, the 64-bit value of the destination register and the 32-bit immediate. The immediate, not the opcode, picks the conversion width of 16, 32 or 64 bits. The host is always little-endian, so the little-endian form only truncates the value to the chosen width. The big-endian form reverses the bytes inside that width and clears every byte above it.

Requests enter on a valid/ready stream. Results leave on a second valid/ready stream through a single register stage. A transfer takes place on a rising edge where valid and ready are both high. A sink that holds `out_ready` low keeps the current result on the outputs without change, and it also stalls the input side, because `in_ready` is high only while the stage is empty or is being drained in that cycle. With `out_ready` held high, each accepted request gives a result that is valid for exactly one cycle. A request with an unsupported width or an unknown opcode is still passed through the stage, but it comes out flagged as illegal, with a zero result and the write-enable low.

Top module: `endcvt_unit`

## Requirements
- R1: Opcode 0xd4 with immediate 16 returns the low 16 bits of the input and clears bits 63:16.
- R2: Opcode 0xd4 with immediate 32 returns the low 32 bits of the input and clears bits 63:32.
- R3: Opcode 0xd4 with immediate 64 returns the input unchanged.
- R4: Opcode 0xdc with immediate 16 returns input byte 0 in result byte 1 and input byte 1 in result byte 0, and zeroes result bytes 7..2.
- R5: Opcode 0xdc with immediate 32 places input byte i in result byte 3-i for i in 0..3, and zeroes result bytes 7..4.
- R6: Opcode 0xdc with immediate 64 places input byte i in result byte 7-i for all eight bytes.
- R7: Any immediate other than 16, 32 or 64 gives `out_illegal`=1, `out_data`=0 and `out_wr_en`=0 for that result.
- R8: Any opcode other than 0xd4 or 0xdc gives `out_illegal`=1, `out_data`=0 and `out_wr_en`=0, whatever the immediate.
- R9: A request accepted on a rising edge has its result presented with `out_valid` high from that same edge. With `out_ready` high and no further request, `out_valid` drops after one cycle.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid`, `out_data`, `out_illegal` stay unchanged on the next edge.
- R11: During and directly after reset, `out_valid` and `out_wr_en` are low and `in_ready` is high.
- R12: `out_wr_en` is high for every valid result of a legal request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_opcode | input | 8 | Instruction opcode (0xd4 little, 0xdc big) |
| in_imm | input | 32 | Immediate; conversion width 16, 32 or 64 |
| in_data | input | 64 | Destination register value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink accepts the result |
| out_data | output | 64 | Converted value |
| out_illegal | output | 1 | Width or opcode not supported |
| out_wr_en | output | 1 | Result may be written back |

## Verification
The bench drives the asymmetric byte pattern 0x0123456789abcdef and other patterns through every opcode and width pair. Because of this, a design that swapped the wrong lanes, reversed over the full word at 16 or 32 bits, or left stale upper bytes gives a result that the scoreboard model detects. It uses immediates that are near-misses, such as 0, 8, 63 and 128, and an opcode one bit away from a legal one. A decoder that matched only part of the field would then raise a write-enable on a zero or wrong result. A repeating stall pattern on `out_ready` shows whether a result changes or is dropped while the sink stalls. A single request with `out_ready` held high shows whether the valid pulse is one cycle wide and arrives in the right cycle.

// File: rtl/endcvt_pkg.sv
package endcvt_pkg;

  typedef enum logic [1:0] {
    SZ_HALF = 2'd0,
    SZ_WORD = 2'd1,
    SZ_FULL = 2'd2,
    SZ_NONE = 2'd3
  } size_e;

  typedef enum logic {
    ORD_TRUNC = 1'b0,
    ORD_SWAP  = 1'b1
  } order_e;

  typedef struct packed {
    order_e order;
    size_e  size;
    logic   bad;
  } conv_ctl_t;

  localparam int unsigned HALF_BITS = 16;
  localparam int unsigned WORD_BITS = 32;
  localparam int unsigned LANE_BITS = 8;

endpackage

// File: rtl/endcvt_decode.sv
module endcvt_decode
  import endcvt_pkg::*;
#(
  parameter int unsigned OPC_W   = 8,
  parameter int unsigned IMM_W   = 32,
  parameter int unsigned DATA_W  = 64,
  parameter logic [OPC_W-1:0] OPC_TRUNC = 8'hd4,
  parameter logic [OPC_W-1:0] OPC_SWAP  = 8'hdc
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [IMM_W-1:0] imm,
  output conv_ctl_t        ctl
);

  localparam logic [IMM_W-1:0] IMM_HALF = IMM_W'(HALF_BITS);
  localparam logic [IMM_W-1:0] IMM_WORD = IMM_W'(WORD_BITS);
  localparam logic [IMM_W-1:0] IMM_FULL = IMM_W'(DATA_W);

  logic  opc_ok;
  size_e sz;

  always_comb begin
    if (imm == IMM_HALF)      sz = SZ_HALF;
    else if (imm == IMM_WORD) sz = SZ_WORD;
    else if (imm == IMM_FULL) sz = SZ_FULL;
    else                      sz = SZ_NONE;
  end

  assign opc_ok = (opcode == OPC_TRUNC) || (opcode == OPC_SWAP);

  always_comb begin
    ctl.order = (opcode == OPC_SWAP) ? ORD_SWAP : ORD_TRUNC;
    ctl.size  = sz;
    ctl.bad   = !opc_ok || (sz == SZ_NONE);
  end

endmodule

// File: rtl/endcvt_lanes.sv
module endcvt_lanes
  import endcvt_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] din,
  input  conv_ctl_t         ctl,
  output logic [DATA_W-1:0] dout
);

  localparam int unsigned NLANE      = DATA_W / LANE_BITS;
  localparam int unsigned HALF_LANES = HALF_BITS / LANE_BITS;
  localparam int unsigned WORD_LANES = WORD_BITS / LANE_BITS;

  logic [DATA_W-1:0] trunc_half, trunc_word;
  logic [DATA_W-1:0] swap_half, swap_word, swap_full;

  assign trunc_half = {{(DATA_W-HALF_BITS){1'b0}}, din[HALF_BITS-1:0]};
  assign trunc_word = {{(DATA_W-WORD_BITS){1'b0}}, din[WORD_BITS-1:0]};

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign swap_full[g*LANE_BITS +: LANE_BITS] =
      din[(NLANE-1-g)*LANE_BITS +: LANE_BITS];
    if (g < HALF_LANES) begin : g_half_in
      assign swap_half[g*LANE_BITS +: LANE_BITS] =
        din[(HALF_LANES-1-g)*LANE_BITS +: LANE_BITS];
    end else begin : g_half_zero
      assign swap_half[g*LANE_BITS +: LANE_BITS] = '0;
    end
    if (g < WORD_LANES) begin : g_word_in
      assign swap_word[g*LANE_BITS +: LANE_BITS] =
        din[(WORD_LANES-1-g)*LANE_BITS +: LANE_BITS];
    end else begin : g_word_zero
      assign swap_word[g*LANE_BITS +: LANE_BITS] = '0;
    end
  end

  always_comb begin
    dout = '0;
    if (!ctl.bad) begin
      unique case (ctl.size)
        SZ_HALF: dout = (ctl.order == ORD_SWAP) ? swap_half : trunc_half;
        SZ_WORD: dout = (ctl.order == ORD_SWAP) ? swap_word : trunc_word;
        SZ_FULL: dout = (ctl.order == ORD_SWAP) ? swap_full : din;
        default: dout = '0;
      endcase
    end
  end

endmodule

// File: rtl/endcvt_stage.sv
module endcvt_stage #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_bad,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_bad
);

  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
    end else if (s_ready) begin
      m_valid <= s_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data <= '0;
      m_bad  <= 1'b0;
    end else if (s_valid && s_ready) begin
      m_data <= s_data;
      m_bad  <= s_bad;
    end
  end

endmodule

// File: rtl/endcvt_unit.sv
module endcvt_unit
  import endcvt_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned OPC_W  = 8,
  parameter int unsigned IMM_W  = 32,
  parameter logic [OPC_W-1:0] OPC_TRUNC = 8'hd4,
  parameter logic [OPC_W-1:0] OPC_SWAP  = 8'hdc
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPC_W-1:0]  in_opcode,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_illegal,
  output logic              out_wr_en
);

  conv_ctl_t         ctl;
  logic [DATA_W-1:0] conv;

  endcvt_decode #(
    .OPC_W(OPC_W), .IMM_W(IMM_W), .DATA_W(DATA_W),
    .OPC_TRUNC(OPC_TRUNC), .OPC_SWAP(OPC_SWAP)
  ) u_decode (
    .opcode(in_opcode),
    .imm   (in_imm),
    .ctl   (ctl)
  );

  endcvt_lanes #(.DATA_W(DATA_W)) u_lanes (
    .din (in_data),
    .ctl (ctl),
    .dout(conv)
  );

  endcvt_stage #(.DATA_W(DATA_W)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(in_valid),
    .s_ready(in_ready),
    .s_data (conv),
    .s_bad  (ctl.bad),
    .m_valid(out_valid),
    .m_ready(out_ready),
    .m_data (out_data),
    .m_bad  (out_illegal)
  );

  assign out_wr_en = out_valid && !out_illegal;

endmodule

// File: rtl/endcvt_checker.sv
module endcvt_checker #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned OPC_W  = 8,
  parameter int unsigned IMM_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OPC_W-1:0]  in_opcode,
  input logic [IMM_W-1:0]  in_imm,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_illegal
);

  logic imm_ok, opc_ok;
  assign imm_ok = (in_imm == IMM_W'(16)) || (in_imm == IMM_W'(32)) ||
                  (in_imm == IMM_W'(DATA_W));
  assign opc_ok = (in_opcode == OPC_W'(8'hd4)) || (in_opcode == OPC_W'(8'hdc));

  assert_bad_width_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !imm_ok |=> out_valid && out_illegal);

  assert_bad_opcode_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !opc_ok |=> out_valid && out_illegal);

  assert_flagged_result_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_data == '0);

  assert_accept_presents_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_illegal));

  assert_stall_blocks_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

endmodule

bind endcvt_unit endcvt_checker #(
  .DATA_W(DATA_W), .OPC_W(OPC_W), .IMM_W(IMM_W)
) u_endcvt_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_opcode(in_opcode), .in_imm(in_imm), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_illegal(out_illegal)
);

// File: tb/endcvt_unit_tb_top.sv
`timescale 1ns/1ps
module endcvt_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = 8'h00;
  logic [31:0] in_imm = 32'd0;
  logic [63:0] in_data = 64'd0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_illegal;
  logic        out_wr_en;

  int n_total = 0;
  int n_bad = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;

  logic [63:0] q_data[$];
  logic        q_ill[$];
  string       q_tag[$];
  int          q_cyc[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  endcvt_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_imm(in_imm), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_illegal(out_illegal), .out_wr_en(out_wr_en)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference behaviour derived from the requirements.
  function automatic logic [64:0] model(input logic [7:0] opc, input logic [31:0] imm,
                                        input logic [63:0] d);
    int nb;
    logic [63:0] r;
    r = '0;
    if (imm == 32'd16) nb = 2;
    else if (imm == 32'd32) nb = 4;
    else if (imm == 32'd64) nb = 8;
    else nb = 0;
    if (nb == 0 || (opc != 8'hd4 && opc != 8'hdc)) return {1'b1, 64'd0};
    for (int i = 0; i < nb; i++) begin
      if (opc == 8'hd4) r[8*i +: 8] = d[8*i +: 8];
      else              r[8*i +: 8] = d[8*(nb-1-i) +: 8];
    end
    return {1'b0, r};
  endfunction

  task automatic send(input logic [7:0] opc, input logic [31:0] imm,
                      input logic [63:0] d, input string tag);
    logic [64:0] e;
    @(negedge clk);
    in_opcode = opc;
    in_imm    = imm;
    in_data   = d;
    in_valid  = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    e = model(opc, imm, d);
    q_ill.push_back(e[64]);
    q_data.push_back(e[63:0]);
    q_tag.push_back(tag);
    q_cyc.push_back(cyc);
    in_valid = 1'b0;
  endtask

  // Sink side: out_ready changes just after a rising edge.
  always @(posedge clk) begin
    #1;
    if (stall_mode) out_ready = (cyc % 3) != 0;
    else            out_ready = 1'b1;
  end

  // Monitor / scoreboard.
  logic        hold_prev = 1'b0;
  logic [63:0] hold_data = '0;
  logic        hold_ill = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev) begin
        check(out_valid === 1'b1, "R10", "held valid", {63'd0, out_valid}, 64'd1);
        check(out_data === hold_data && out_illegal === hold_ill, "R10", "held data",
              out_data, hold_data);
      end
      if (out_valid && !out_ready)
        check(in_ready === 1'b0, "R10", "in_ready under stall", {63'd0, in_ready}, 64'd0);
      hold_prev = out_valid && !out_ready;
      hold_data = out_data;
      hold_ill  = out_illegal;
      if (out_valid && out_ready) begin
        if (q_data.size() == 0) begin
          check(1'b0, "R9", "unexpected result", out_data, 64'd0);
        end else begin
          logic [63:0] ed;
          logic        ei;
          string       et;
          int          ec;
          ed = q_data.pop_front();
          ei = q_ill.pop_front();
          et = q_tag.pop_front();
          ec = q_cyc.pop_front();
          check(out_data === ed, et, "data", out_data, ed);
          check(out_illegal === ei, ei ? et : "R12", "illegal flag", {63'd0, out_illegal}, {63'd0, ei});
          check(out_wr_en === !ei, ei ? et : "R12", "write enable", {63'd0, out_wr_en}, {63'd0, !ei});
          if (!stall_mode)
            check(cyc == ec, "R9", "latency", 64'(cyc), 64'(ec));
        end
      end
    end
  end

  task automatic drain();
    int guard = 0;
    while ((q_data.size() != 0 || out_valid) && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_total++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R11", "out_valid in reset", {63'd0, out_valid}, 64'd0);
    check(out_wr_en === 1'b0, "R11", "out_wr_en in reset", {63'd0, out_wr_en}, 64'd0);
    check(in_ready === 1'b1, "R11", "in_ready in reset", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R11", "out_valid after reset", {63'd0, out_valid}, 64'd0);

    // Little-endian truncation.
    send(8'hd4, 32'd16, 64'h0123456789abcdef, "R1");
    send(8'hd4, 32'd16, 64'hffffffffffff8001, "R1");
    send(8'hd4, 32'd32, 64'h0123456789abcdef, "R2");
    send(8'hd4, 32'd32, 64'h80000000fedcba98, "R2");
    send(8'hd4, 32'd64, 64'h0123456789abcdef, "R3");
    send(8'hd4, 32'd64, 64'hdeadbeefcafef00d, "R3");
    // Big-endian reversal.
    send(8'hdc, 32'd16, 64'h0123456789abcdef, "R4");
    send(8'hdc, 32'd16, 64'hffffffffffff00ff, "R4");
    send(8'hdc, 32'd32, 64'h0123456789abcdef, "R5");
    send(8'hdc, 32'd32, 64'hffffffff11223344, "R5");
    send(8'hdc, 32'd64, 64'h0123456789abcdef, "R6");
    send(8'hdc, 32'd64, 64'h8000000000000001, "R6");
    // Unsupported widths.
    send(8'hdc, 32'd0,   64'h0123456789abcdef, "R7");
    send(8'hd4, 32'd8,   64'h0123456789abcdef, "R7");
    send(8'hdc, 32'd63,  64'h0123456789abcdef, "R7");
    send(8'hd4, 32'd128, 64'h0123456789abcdef, "R7");
    send(8'hdc, 32'h00010010, 64'h0123456789abcdef, "R7");
    // Unknown opcodes.
    send(8'hd5, 32'd16, 64'h0123456789abcdef, "R8");
    send(8'hcc, 32'd64, 64'h0123456789abcdef, "R8");
    send(8'h5c, 32'd32, 64'h0123456789abcdef, "R8");
    drain();

    // Single pulse: one request, sink always ready.
    send(8'hdc, 32'd32, 64'h00000000a1b2c3d4, "R9");
    @(negedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R9", "pulse width", {63'd0, out_valid}, 64'd0);

    // Back-pressure stream.
    stall_mode = 1'b1;
    for (int k = 0; k < 24; k++) begin
      send((k % 2) ? 8'hdc : 8'hd4, (k % 3 == 0) ? 32'd16 : ((k % 3 == 1) ? 32'd32 : 32'd64),
           {32'(k) * 32'h01010101, 32'h89abcdef ^ 32'(k)}, "R10");
    end
    drain();
    stall_mode = 1'b0;
    repeat (4) @(negedge clk);
    check(q_data.size() == 0, "R10", "all results delivered", 64'(q_data.size()), 64'd0);

    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

endmodule